// File: doc/BRIEF.md
# Clock Ratio Controller

This block is the digital core of a clock generator. It runs from one fast source clock and turns it into three one-cycle enables: a reference tick that marks the phase of the external reference (the fast clock is that reference times a multiplier), a core tick for the internal/peripheral clock, and a timer tick for a timer clock. Each tick is high for one source cycle in every N source cycles, where N is the ratio currently in force. A ratio of 1 holds the tick high continuously.

Software programs the ratios through a small write port that reaches three registers: a frequency register (multiplier code and core divider code), a timer register (timer divider code) and a status register (write-one-to-clear error bit). Every configuration write is checked against the allowed code tables and two cross-clock rules. A legal write becomes pending. An illegal write changes nothing and sets a sticky error flag.

A two-state controller (`ST_IDLE`, `ST_PEND`) applies pending ratios only at a common boundary of all three ticks. Its transitions are: `ACCEPT` (`ST_IDLE` to `ST_PEND` on a legal write), `APPLY` (`ST_PEND` to `ST_IDLE` when every divider ends its period in the same cycle and no legal write arrives), and `REAPPLY` (stay in `ST_PEND` when a legal write lands in the apply cycle itself). The active and pending settings can both be read back.

Top module: `clk_ratio_ctrl`

## Requirements
- R1: After reset, the active and pending settings are all code 0, so the multiplier and both divide values are 1. All three ticks are high on every cycle, `cfg_err` is 0 and `cfg_pending` is 0.
- R2: Frequency register write (`wr_sel`=0): `wr_data[2:0]` is the multiplier code. Codes 0..5 select 1, 2, 3, 4, 6 and 8. Codes 6 and 7 are illegal.
- R3: Frequency register write: `wr_data[5:3]` is the core divider code. Codes 0..6 select 1, 2, 3, 4, 6, 8 and 12, and code 7 is illegal. A core divide value larger than the multiplier is illegal.
- R4: Timer register write (`wr_sel`=1): `wr_data[2:0]` is the timer divider code. Codes 0..3 select 1, 2, 3 and 4. Codes 4..7 are illegal.
- R5: A setting whose core divide value is not an exact multiple of the timer divide value is illegal. A frequency write is validated against the pending timer code, and a timer write against the pending frequency codes.
- R6: An illegal configuration write leaves the pending settings and the active settings unchanged. It sets `cfg_err` on the next cycle, and the flag then stays set.
- R7: A status write (`wr_sel`=2) with `wr_data[0]`=1 clears `cfg_err`. A status write with `wr_data[0]`=0 leaves it set.
- R8: A legal write appears on `rd_pending` on the next cycle and raises `cfg_pending`. The pending settings become active on the first edge after a cycle in which all three dividers end their period together. The cycle after that edge shows all three ticks high.
- R9: With ratio N active, each tick is high for exactly one cycle in every N cycles. With N=1 the tick stays high.
- R10: `rd_active` and `rd_pending` pack the settings as follows: bits [2:0] hold the multiplier code, bits [5:3] the core divider code and bits [8:6] the timer divider code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 frequency, 1 timer, 2 status |
| wr_data | input | 6 | Write data |
| ref_tick | output | 1 | Enable at the external reference rate (period = multiplier) |
| core_tick | output | 1 | Enable for the internal/peripheral clock |
| tmr_tick | output | 1 | Enable for the timer clock |
| cfg_err | output | 1 | Sticky flag for a rejected write |
| cfg_pending | output | 1 | Legal settings waiting for alignment |
| rd_active | output | 9 | Settings in force |
| rd_pending | output | 9 | Settings last accepted |

## Verification
The tick generators are tried with even ratio sets (4/2/1, 8/8/2) and with sets that mix odd and even ratios (6/6/3, 3/3/3). The mixed sets separate a true common-boundary apply from one that waits only for a single divider's wrap. Rejections are tried one rule at a time: an unused code in each field, a core divide above the multiplier, and a core divide that is not a multiple of the timer divide. Each one shows whether that specific rule alone blocks the write and leaves both read-back ports untouched. The status clear is tried with data 0 and data 1 to tell write-one-to-clear apart from write-any-to-clear.

// File: rtl/clkr_pkg.sv
package clkr_pkg;

    localparam int IDX_W = 3;
    localparam int VAL_W = 4;

    typedef struct packed {
        logic [IDX_W-1:0] tdiv;
        logic [IDX_W-1:0] cdiv;
        logic [IDX_W-1:0] mul;
    } ratio_set_t;

    typedef enum logic {
        ST_IDLE,
        ST_PEND
    } ctl_state_t;

    // Returns 0 for an unused code
    function automatic logic [VAL_W-1:0] mul_value(input logic [IDX_W-1:0] code);
        unique case (code)
            3'd0:    mul_value = 4'd1;
            3'd1:    mul_value = 4'd2;
            3'd2:    mul_value = 4'd3;
            3'd3:    mul_value = 4'd4;
            3'd4:    mul_value = 4'd6;
            3'd5:    mul_value = 4'd8;
            default: mul_value = 4'd0;
        endcase
    endfunction

    function automatic logic [VAL_W-1:0] cdiv_value(input logic [IDX_W-1:0] code);
        unique case (code)
            3'd0:    cdiv_value = 4'd1;
            3'd1:    cdiv_value = 4'd2;
            3'd2:    cdiv_value = 4'd3;
            3'd3:    cdiv_value = 4'd4;
            3'd4:    cdiv_value = 4'd6;
            3'd5:    cdiv_value = 4'd8;
            3'd6:    cdiv_value = 4'd12;
            default: cdiv_value = 4'd0;
        endcase
    endfunction

    function automatic logic [VAL_W-1:0] tdiv_value(input logic [IDX_W-1:0] code);
        unique case (code)
            3'd0:    tdiv_value = 4'd1;
            3'd1:    tdiv_value = 4'd2;
            3'd2:    tdiv_value = 4'd3;
            3'd3:    tdiv_value = 4'd4;
            default: tdiv_value = 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/clkr_ratio_check.sv
module clkr_ratio_check
    import clkr_pkg::*;
(
    input  ratio_set_t cand,
    output logic       legal
);
    logic [VAL_W-1:0] m_v, c_v, t_v;
    logic             codes_ok, slow_ok, mult_ok;

    always_comb begin
        m_v      = mul_value(cand.mul);
        c_v      = cdiv_value(cand.cdiv);
        t_v      = tdiv_value(cand.tdiv);
        codes_ok = (m_v != '0) && (c_v != '0) && (t_v != '0);
        // core clock may not run below the reference clock
        slow_ok  = (c_v <= m_v);
        // timer clock must be an integer multiple of the core clock
        mult_ok  = (t_v != '0) ? ((c_v % t_v) == '0) : 1'b0;
        legal    = codes_ok && slow_ok && mult_ok;
    end
endmodule

// File: rtl/clkr_tick_div.sv
module clkr_tick_div #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] ratio,
    output logic             tick,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    assign tick = (cnt_q == '0);
    assign last = (cnt_q == ratio - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (last) cnt_q <= '0;
        else           cnt_q <= cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/clk_ratio_ctrl.sv
module clk_ratio_ctrl
    import clkr_pkg::*;
#(
    parameter int SEL_W   = 2,
    parameter int NUM_DIV = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [SEL_W-1:0]     wr_sel,
    input  logic [2*IDX_W-1:0]   wr_data,
    output logic                 ref_tick,
    output logic                 core_tick,
    output logic                 tmr_tick,
    output logic                 cfg_err,
    output logic                 cfg_pending,
    output logic [3*IDX_W-1:0]   rd_active,
    output logic [3*IDX_W-1:0]   rd_pending
);
    localparam logic [SEL_W-1:0] SEL_FREQ = SEL_W'(0);
    localparam logic [SEL_W-1:0] SEL_TMR  = SEL_W'(1);
    localparam logic [SEL_W-1:0] SEL_STAT = SEL_W'(2);

    ctl_state_t state_q, state_d;
    ratio_set_t act_q, pend_q, cand;
    logic       err_q;
    logic       cfg_wr, clr_wr, legal, accept, reject, aligned;

    logic [VAL_W-1:0]   ratio_v [NUM_DIV];
    logic [NUM_DIV-1:0] tick, last;

    // candidate = pending settings with the written field replaced
    always_comb begin
        cand = pend_q;
        unique case (wr_sel)
            SEL_FREQ: begin
                cand.mul  = wr_data[IDX_W-1:0];
                cand.cdiv = wr_data[2*IDX_W-1:IDX_W];
            end
            SEL_TMR:  cand.tdiv = wr_data[IDX_W-1:0];
            default:  cand = pend_q;
        endcase
    end

    clkr_ratio_check u_check (
        .cand  (cand),
        .legal (legal)
    );

    assign cfg_wr  = wr_en && ((wr_sel == SEL_FREQ) || (wr_sel == SEL_TMR));
    assign clr_wr  = wr_en && (wr_sel == SEL_STAT) && wr_data[0];
    assign accept  = cfg_wr && legal;
    assign reject  = cfg_wr && !legal;
    assign aligned = &last;

    // divider bank: 0 reference, 1 core, 2 timer
    assign ratio_v[0] = mul_value(act_q.mul);
    assign ratio_v[1] = cdiv_value(act_q.cdiv);
    assign ratio_v[2] = tdiv_value(act_q.tdiv);

    for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
        clkr_tick_div #(.CNT_W(VAL_W)) u_div (
            .clk   (clk),
            .rst_n (rst_n),
            .ratio (ratio_v[g]),
            .tick  (tick[g]),
            .last  (last[g])
        );
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state: ACCEPT, APPLY, REAPPLY
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept)             state_d = ST_PEND;
            ST_PEND: if (aligned && !accept) state_d = ST_IDLE;
            default:                         state_d = ST_IDLE;
        endcase
    end

    // settings and error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= '0;
            pend_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if ((state_q == ST_PEND) && aligned) act_q <= pend_q;
            if (accept)                          pend_q <= cand;
            if (reject)                          err_q <= 1'b1;
            else if (clr_wr)                     err_q <= 1'b0;
        end
    end

    assign ref_tick    = tick[0];
    assign core_tick   = tick[1];
    assign tmr_tick    = tick[2];
    assign cfg_err     = err_q;
    assign cfg_pending = (state_q == ST_PEND);
    assign rd_active   = act_q;
    assign rd_pending  = pend_q;
endmodule

// File: rtl/clk_ratio_ctrl_chk.sv
module clk_ratio_ctrl_chk
    import clkr_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] wr_sel,
    input logic       clr_bit,
    input logic       ref_tick,
    input logic       core_tick,
    input logic       tmr_tick,
    input logic       cfg_err,
    input logic       cfg_pending,
    input logic [8:0] rd_active,
    input logic [8:0] rd_pending
);
    logic [VAL_W-1:0] a_m, a_c, a_t;
    assign a_m = mul_value(rd_active[2:0]);
    assign a_c = cdiv_value(rd_active[5:3]);
    assign a_t = tdiv_value(rd_active[8:6]);

    // R3: active core divide never exceeds the multiplier
    p_core_not_slow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (a_c != '0) && (a_c <= a_m));

    // R5: active timer divide always divides the core divide
    p_tmr_multiple_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (a_t != '0) && ((a_c % a_t) == '0));

    // R8: a change of active settings is followed by all ticks high
    p_apply_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_active) |-> (ref_tick && core_tick && tmr_tick));

    // R8: without pending settings nothing is applied
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_pending |=> $stable(rd_active));

    // R7: error flag stays set unless cleared by a status write of 1
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && !(wr_en && (wr_sel == 2'd2) && clr_bit)) |=> cfg_err);

    // R6: pending settings stay put while nothing is accepted
    p_pend_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || (wr_sel[1] == 1'b1)) |=> $stable(rd_pending));

    // R9: divide-by-1 keeps the core tick high
    p_core_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_active[5:3] == 3'd0) |-> core_tick);
endmodule

bind clk_ratio_ctrl clk_ratio_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .clr_bit     (wr_data[0]),
    .ref_tick    (ref_tick),
    .core_tick   (core_tick),
    .tmr_tick    (tmr_tick),
    .cfg_err     (cfg_err),
    .cfg_pending (cfg_pending),
    .rd_active   (rd_active),
    .rd_pending  (rd_pending)
);

// File: tb/clk_ratio_ctrl_bench.sv
module clk_ratio_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [5:0] wr_data = 6'd0;
    logic       ref_tick, core_tick, tmr_tick, cfg_err, cfg_pending;
    logic [8:0] rd_active, rd_pending;

    int n_checks = 0;
    int n_fails  = 0;

    typedef struct packed {
        logic [8:0] pend;
        logic [8:0] act;
        logic       err;
        logic [7:0] req;
    } sb_item_t;

    sb_item_t sbq[$];

    logic [8:0] exp_act  = 9'd0;
    logic [8:0] exp_pend = 9'd0;
    logic       exp_err  = 1'b0;

    always #4 clk = ~clk;

    clk_ratio_ctrl u_clk_ratio_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .ref_tick    (ref_tick),
        .core_tick   (core_tick),
        .tmr_tick    (tmr_tick),
        .cfg_err     (cfg_err),
        .cfg_pending (cfg_pending),
        .rd_active   (rd_active),
        .rd_pending  (rd_pending)
    );

    // bench-side tables: R2, R3, R4
    function automatic int mul_of(input int c);
        case (c) 0: return 1; 1: return 2; 2: return 3; 3: return 4;
                 4: return 6; 5: return 8; default: return 0; endcase
    endfunction
    function automatic int cdv_of(input int c);
        case (c) 0: return 1; 1: return 2; 2: return 3; 3: return 4;
                 4: return 6; 5: return 8; 6: return 12; default: return 0; endcase
    endfunction
    function automatic int tdv_of(input int c);
        case (c) 0: return 1; 1: return 2; 2: return 3; 3: return 4;
                 default: return 0; endcase
    endfunction
    function automatic bit set_ok(input logic [8:0] s);
        int m, c, t;
        m = mul_of(int'(s[2:0]));
        c = cdv_of(int'(s[5:3]));
        t = tdv_of(int'(s[8:6]));
        if (m == 0 || c == 0 || t == 0) return 1'b0;
        if (c > m) return 1'b0;        // R3
        return (c % t) == 0;           // R5
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // monitor: compares the registered result of each write
    initial begin
        forever begin
            @(posedge clk);
            if (wr_en) begin
                @(negedge clk);
                if (sbq.size() != 0) begin
                    sb_item_t it;
                    string    rq;
                    it = sbq.pop_front();
                    rq = $sformatf("R%0d", it.req);
                    check(rd_pending == it.pend, rq, "rd_pending", rd_pending, it.pend);
                    check(rd_active == it.act, rq, "rd_active", rd_active, it.act);
                    check(cfg_err == it.err, rq, "cfg_err", cfg_err, it.err);
                end
            end
        end
    end

    // driver: one register write, expectation pushed to the scoreboard
    task automatic drive(input logic [1:0] sel, input logic [5:0] data, input int req);
        logic [8:0] cand;
        sb_item_t   it;
        cand = exp_pend;
        if (sel == 2'd0) begin
            cand[2:0] = data[2:0];
            cand[5:3] = data[5:3];
        end else if (sel == 2'd1) begin
            cand[8:6] = data[2:0];
        end
        if (sel == 2'd2) begin
            if (data[0]) exp_err = 1'b0;   // R7
        end else if (set_ok(cand)) begin
            exp_pend = cand;
        end else begin
            exp_err = 1'b1;                // R6
        end
        it.pend = exp_pend;
        it.act  = exp_act;
        it.err  = exp_err;
        it.req  = 8'(req);
        @(negedge clk);
        sbq.push_back(it);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // R8: wait for the pending settings to be applied
    task automatic wait_apply();
        bit seen = 1'b0;
        for (int i = 0; i < 64 && !seen; i++) begin
            if (rd_active == exp_pend) seen = 1'b1;
            else @(negedge clk);
        end
        check(seen, "R8", "apply reached", rd_active, exp_pend);
        check(ref_tick && core_tick && tmr_tick, "R8", "ticks aligned at apply",
              {ref_tick, core_tick, tmr_tick}, 7);
        exp_act = exp_pend;
        @(negedge clk);
        check(cfg_pending == 1'b0, "R8", "pending cleared", cfg_pending, 0);
    endtask

    function automatic logic pick(input int w);
        case (w) 0: return ref_tick; 1: return core_tick; default: return tmr_tick; endcase
    endfunction

    // R9: period between consecutive ticks
    task automatic period(input int w, input int exp);
        int n = 0;
        for (int i = 0; i < 64 && !pick(w); i++) @(negedge clk);
        @(negedge clk);
        n = 1;
        while (!pick(w) && n < 64) begin
            @(negedge clk);
            n++;
        end
        check(n == exp, "R9", $sformatf("tick %0d period", w), n, exp);
    endtask

    task automatic periods_all();
        period(0, mul_of(int'(exp_act[2:0])));
        period(1, cdv_of(int'(exp_act[5:3])));
        period(2, tdv_of(int'(exp_act[8:6])));
    endtask

    // watchdog
    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(rd_active == 9'd0, "R1", "active after reset", rd_active, 0);
        check(rd_pending == 9'd0, "R1", "pending after reset", rd_pending, 0);
        check(!cfg_err && !cfg_pending, "R1", "flags after reset", {cfg_err, cfg_pending}, 0);
        for (int i = 0; i < 4; i++) begin
            check(ref_tick && core_tick && tmr_tick, "R1", "ticks steady",
                  {ref_tick, core_tick, tmr_tick}, 7);
            @(negedge clk);
        end

        // R2 R3: multiplier 4, core divide 2
        drive(2'd0, {3'd1, 3'd3}, 2);
        check(cfg_pending, "R8", "pending raised", cfg_pending, 1);
        wait_apply();
        // R10: field positions of the read-back
        check(rd_active[2:0] == 3'd3 && rd_active[5:3] == 3'd1, "R10", "field layout",
              rd_active, 9'b000_001_011);
        periods_all();

        // R4: timer divide 2
        drive(2'd1, 6'd1, 4);
        wait_apply();
        periods_all();

        // R2: unused multiplier code
        drive(2'd0, {3'd1, 3'd6}, 2);
        // R7: status write of 0 keeps flag, of 1 clears it
        drive(2'd2, 6'd0, 7);
        drive(2'd2, 6'd1, 7);
        // R3: core divide 6 above multiplier 4
        drive(2'd0, {3'd4, 3'd3}, 3);
        drive(2'd2, 6'd1, 7);
        // R3: unused core code
        drive(2'd0, {3'd7, 3'd5}, 3);
        drive(2'd2, 6'd1, 7);
        // R6: active ratios untouched by rejected writes
        periods_all();

        // multiplier 8, core divide 8
        drive(2'd0, {3'd5, 3'd5}, 3);
        wait_apply();
        periods_all();

        // R5: timer 3 does not divide 8
        drive(2'd1, 6'd2, 5);
        drive(2'd2, 6'd1, 7);
        // R4: unused timer code
        drive(2'd1, 6'd4, 4);
        drive(2'd2, 6'd1, 7);

        // odd/even mix: 6/6/2 then timer 3
        drive(2'd0, {3'd4, 3'd4}, 3);
        wait_apply();
        drive(2'd1, 6'd2, 5);
        wait_apply();
        periods_all();

        // R5: frequency write checked against pending timer 3 (4 not a multiple)
        drive(2'd0, {3'd3, 3'd3}, 5);
        drive(2'd2, 6'd1, 7);

        // 3/3/3
        drive(2'd0, {3'd2, 3'd2}, 9);
        wait_apply();
        periods_all();

        repeat (4) @(negedge clk);
        check(sbq.size() == 0, "R6", "scoreboard drained", sbq.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule